// File: doc/BRIEF.md
# Per-Word Frame Sync Generator

This block derives a frame-sync strobe for every serial word from a single packet-wide, active-low SPI select. An SPI master fed by DMA typically holds its select low for an entire multi-byte burst, while a serial audio codec wants a sync pulse ahead of each word. The generator watches that select and the bit-clock enable of the SPI shifter. It counts bit ticks and raises a one-slot, active-high sync at the start of every word for as long as the packet lasts.

It runs from the same clock as the SPI shifter, with a one-cycle bit enable (`bit_en`) marking each bit period. A registered copy of the select finds the falling edge that starts a packet. That edge restarts the bit counter, so the word boundaries line up with the burst rather than free-running. When the select rises, the count stops at once and no further sync appears until the next packet starts. The word length is a parameter, `WORD_BITS`, with a default of 8.

Top module: `frame_sync_gen`

## Requirements
- R1: `rst` is synchronous and active-high. It clears the bit counter and returns the select register to its idle value (high). In the cycle after a reset edge, `fsync` is 0.
- R2: While `sel_n` is 1, the bit counter is held at 0 and `bit_en` is ignored. In the cycle after any clock edge at which `sel_n` was 1, `fsync` is 0.
- R3: A packet start is a clock edge at which `sel_n` is 0 and the registered select is 1. This edge puts the counter at slot 0 even if `bit_en` is 1 in that cycle. In the next cycle, `fsync` is 1.
- R4: While `sel_n` stays 0, each edge with `bit_en` = 1 moves the slot from k to k+1, wrapping from `WORD_BITS`-1 to 0. Edges with `bit_en` = 0 leave the slot unchanged. `fsync` is 1 exactly in the cycles when the slot is 0 and the registered select is 0.
- R5: A packet of K words has K·`WORD_BITS` bit ticks, and `sel_n` rises in the same cycle as the last tick. Such a packet yields exactly K rising edges of `fsync`; with 16 bytes at the default width, that is 16 pulses.
- R6: If `sel_n` rises in the middle of a word, `fsync` is 0 from the next cycle on. It stays 0 until the next packet start, whatever `bit_en` does in the meantime.
- R7: `WORD_BITS` sets the pulse period in bit ticks. An instance with `WORD_BITS` = 5 pulses once every 5 ticks under the same rules.
- R8: `bit_en` ticks seen before a packet start do not shift its phase. The first wrap after the start happens on exactly the `WORD_BITS`-th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shifter clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Packet select from the SPI master, active low |
| bit_en | input | 1 | One-cycle strobe marking each serial bit period |
| fsync | output | 1 | Per-word frame sync, active high, one bit slot wide |

## Verification
The bench drives full 16-byte bursts in several ways: with a tick every cycle, with a tick every third cycle, and with a tick landing on the cycle of the falling select edge. Counting the pulses in these bursts separates a correct wrap from an off-by-one period or a missing restart. Selects aborted mid-word, and ticks arriving while the select is idle, show whether the count really stops, and whether stale phase leaks into the next packet. A long stretch of random select toggling and random tick density runs against a per-cycle reference model on two instances of different word length. This exposes any slot that drifts when the enable is sparse.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // Width of a slot counter able to hold 0 .. n-1 (never below 1 bit).
  function automatic int unsigned slot_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Slot reached after one bit tick from slot cur in a word of n bits.
  function automatic int unsigned slot_after(input int unsigned cur,
                                             input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/fsg_sel_edge.sv
module fsg_sel_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  output logic sel_q,
  output logic start
);

  // Registered select; reset value is the idle (deselected) level.
  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b1;
    else     sel_q <= sel_n;
  end

  // Packet start: the select was idle last edge and is active now.
  assign start = sel_q & ~sel_n;

  // R3: after a detected start the registered select is active.
  AST_START_LATCHED: assert property (@(posedge clk) disable iff (rst)
    start |=> !sel_q); // R3

endmodule

// File: rtl/fsg_slot_counter.sv
module fsg_slot_counter #(
  parameter int unsigned WORD_BITS = 8,
  localparam int unsigned CW = fsg_pkg::slot_width(WORD_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] slot,
  output logic          wrap
);

  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  logic [CW-1:0] slot_next;

  assign wrap      = step & (slot == LAST);
  assign slot_next = CW'(fsg_pkg::slot_after(int'(slot), WORD_BITS));

  always_ff @(posedge clk) begin
    if (rst || clear) slot <= '0;
    else if (step)    slot <= slot_next;
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST); // R7
  AST_SLOT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clear |=> slot == '0); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(slot)); // R4

endmodule

// File: rtl/fsg_sync_drive.sv
module fsg_sync_drive #(
  parameter int unsigned WORD_BITS = 8,
  localparam int unsigned CW = fsg_pkg::slot_width(WORD_BITS)
) (
  input  logic          sel_q,
  input  logic [CW-1:0] slot,
  output logic          fsync
);

  // Sync covers slot 0 of each word while the registered select is active.
  always_comb begin
    fsync = 1'b0;
    if (!sel_q && slot == '0) fsync = 1'b1;
  end

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic bit_en,
  output logic fsync
);

  localparam int unsigned CW = fsg_pkg::slot_width(WORD_BITS);

  logic          sel_q;
  logic          pkt_start;
  logic          cnt_clear;
  logic          word_wrap;
  logic [CW-1:0] slot;

  fsg_sel_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .sel_n (sel_n),
    .sel_q (sel_q),
    .start (pkt_start)
  );

  // Count only inside a packet; a start also restarts the phase.
  assign cnt_clear = sel_n | pkt_start;

  fsg_slot_counter #(.WORD_BITS(WORD_BITS)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clear (cnt_clear),
    .step  (bit_en),
    .slot  (slot),
    .wrap  (word_wrap)
  );

  fsg_sync_drive #(.WORD_BITS(WORD_BITS)) u_drv (
    .sel_q (sel_q),
    .slot  (slot),
    .fsync (fsync)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> !fsync); // R2
  AST_FIRST_SYNC: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> fsync); // R3
  AST_WRAP_SYNC: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !pkt_start && word_wrap) |=> fsync); // R4
  AST_MIDWORD_NOSYNC: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !pkt_start && bit_en && !word_wrap) |=> !fsync); // R4
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_n) |=> !fsync); // R6

endmodule

// File: tb/sim_frame_sync_gen.sv
module sim_frame_sync_gen;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic bit_en = 1'b0;
  logic fs0, fs1;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  frame_sync_gen u0 (.clk(clk), .rst(rst), .sel_n(sel_n), .bit_en(bit_en), .fsync(fs0));
  frame_sync_gen #(.WORD_BITS(5)) u1 (.clk(clk), .rst(rst), .sel_n(sel_n), .bit_en(bit_en), .fsync(fs1));

  // Reference: registered select level and current slot per instance.
  bit m_selq;
  int m_slot0, m_slot1;

  function automatic int advance(input int cur, input int n, input bit tick);
    return tick ? (cur + 1) % n : cur;
  endfunction

  function automatic bit want_sync(input bit selq, input int slot);
    return !selq && slot == 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_selq <= 1'b1; m_slot0 <= 0; m_slot1 <= 0;
    end else begin
      m_selq <= sel_n;
      if (sel_n || m_selq) begin
        m_slot0 <= 0; m_slot1 <= 0;
      end else begin
        m_slot0 <= advance(m_slot0, 8, bit_en);
        m_slot1 <= advance(m_slot1, 5, bit_en);
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  int  rises = 0;
  bit  prev0 = 1'b0;

  // Sample at the falling edge, then drive the next inputs.
  task automatic tick(input string tag, input bit s, input bit e);
    @(negedge clk);
    check(tag, fs0, want_sync(m_selq, m_slot0));
    check("R7", fs1, want_sync(m_selq, m_slot1));
    if (fs0 && !prev0) rises++;
    prev0 = fs0;
    sel_n = s; bit_en = e;
  endtask

  // Burst of words*8 ticks, one every gap cycles; select rises on the last.
  task automatic burst(input string tag, input int words, input int gap, input bit en_at_start);
    int total = words * 8;
    tick(tag, 1'b0, en_at_start);
    rises = 0; prev0 = 1'b0;
    for (int t = 0; t < total; t++) begin
      for (int g = 1; g < gap; g++) tick(tag, 1'b0, 1'b0);
      tick(tag, (t == total - 1), 1'b1);
    end
    tick(tag, 1'b1, 1'b0);
    tick(tag, 1'b1, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", fs0, 0);
    @(negedge clk); rst = 1'b0;
    tick("R1", 1'b1, 1'b0);
    check("R1", fs0, 0);

    // R2: idle with ticks present stays quiet
    for (int i = 0; i < 20; i++) tick("R2", 1'b1, 1'($urandom % 2));
    check("R2", fs0, 0);

    // R5: 16-byte bursts, dense, sparse, tick on start cycle (R3)
    burst("R5", 16, 1, 1'b0);
    check("R5", rises, 16);
    burst("R5", 16, 3, 1'b0);
    check("R5", rises, 16);
    burst("R3", 16, 1, 1'b1);
    check("R3", rises, 16);
    burst("R5", 1, 2, 1'b0);
    check("R5", rises, 1);

    // R6: abort in mid-word, ticks while idle, then restart
    tick("R6", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick("R6", 1'b0, 1'b1);
    tick("R6", 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) tick("R6", 1'b1, 1'b1);
    @(negedge clk);
    check("R6", fs0, 0);

    // R8: first wrap lands on exactly the 8th tick after the start
    sel_n = 1'b0; bit_en = 1'b0;
    @(negedge clk); check("R3", fs0, 1);
    for (int i = 0; i < 7; i++) begin
      bit_en = 1'b1; @(negedge clk);
      check("R8", fs0, 0);
    end
    bit_en = 1'b1; @(negedge clk);
    check("R8", fs0, 1);
    bit_en = 1'b0; sel_n = 1'b1;
    @(negedge clk); check("R6", fs0, 0);

    // Random phase: select toggles and tick density vary
    for (int i = 0; i < 3000; i++) begin
      bit s = ($urandom % 40 == 0) ? ~sel_n : sel_n;
      tick("R4", s, ($urandom % 4) != 0 ? 1'b1 : 1'b0);
    end

    // R1: reset in the middle of a packet
    tick("R4", 1'b0, 1'b1);
    tick("R4", 1'b0, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); check("R1", fs0, 0);
    rst = 1'b0; sel_n = 1'b1; bit_en = 1'b0;
    tick("R1", 1'b1, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule